// File: doc/BRIEF.md
# Burst-of-Two Pipelined SRAM with Posted Write

This block models a synchronous pipelined SRAM that moves two words per access. It runs in one clock domain. The double-rate data path is folded into two lanes per cycle: lane 0 carries the word of the rising half and lane 1 the word of the falling half. A command is taken on a clock edge when the active-low load input is low. The read/write select then picks a read (high) or a write (low). The word address seeds a one-bit linear burst counter, so lane 0 maps to the addressed word and lane 1 to the word whose address has its LSB incremented modulo two.

A write is not put into the array at once. Its address, both data words and both byte-enable pairs are held in a posted-write register. That register is committed to the array only when the data of the next write is captured, so reads issued in between leave it in place. A read compares its word addresses with the held entry. For each enabled byte it takes the held data, and for the other bytes it takes the array. Read data comes out through a one- or two-stage output pipeline chosen by a latency strap, with a valid strobe.

Top module: `burst2_sram`

## Requirements
- R1: A command is accepted at a rising clock edge only when `ld_ni` is 0. `rw_i`=1 selects a read and `rw_i`=0 selects a write. With `ld_ni`=1 the address, select and data inputs neither start a read nor change the stored contents.
- R2: A burst at address A uses word A on lane 0 and word {A[7:1], A[0]+1 mod 2} on lane 1, for reads and writes alike.
- R3: The write data of a command taken at edge n is sampled at edge n+1: `wdata0_i` with `wbe0_i`, and `wdata1_i` with `wbe1_i`. The data inputs in any other cycle are ignored.
- R4: Byte enables are active high. Bit 0 covers data bits 8:0 and bit 1 covers bits 17:9. A byte whose enable is 0 keeps its previous stored value.
- R5: The latest write is held and written to the array only when the next write's data is captured. Any number of reads in between return its data.
- R6: A read returns, per byte, the newest written value. This includes a write whose command was taken in the immediately preceding cycle and a write merged over older bytes of the same word.
- R7: With `lat_norm_i`=1, read data and `rvalid_o` appear after the second rising edge following the command edge. With `lat_norm_i`=0 they appear after the first.
- R8: `rvalid_o` is 1 for exactly one cycle per accepted read. When it is 0, both read lanes are 0.
- R9: Commands may be accepted on every cycle in any mix of reads and writes, and each one completes.
- R10: Reset clears the array, the held write and the outputs, so a read after reset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lat_norm_i | input | 1 | Latency strap: 1 long, 0 short (static) |
| ld_ni | input | 1 | Command load, active low |
| rw_i | input | 1 | 1 read, 0 write |
| addr_i | input | 8 | Burst word address |
| wdata0_i | input | 18 | Write word, lane 0 |
| wdata1_i | input | 18 | Write word, lane 1 |
| wbe0_i | input | 2 | Byte enables, lane 0 |
| wbe1_i | input | 2 | Byte enables, lane 1 |
| rdata0_o | output | 18 | Read word, lane 0 |
| rdata1_o | output | 18 | Read word, lane 1 |
| rvalid_o | output | 1 | Read data valid |

## Verification
One command sequence is run under both latency straps. It reads before any write to show cleared contents. It reads straight after a write to tell bypass from array data, and reads at the odd address of a pair to expose the lane order. Two back-to-back partial writes to one pair are then read, which separates a correct per-byte merge of held and committed bytes from whole-word selection. Fully masked writes, idle cycles that carry write-like inputs, and reads of old data behind a newer held write show whether stray data reaches the array and whether the held entry is committed early.

// File: rtl/sram2_pkg.sv
`timescale 1ns/1ps
package sram2_pkg;
  localparam int ADDR_W_DEF = 8;
  localparam int WORD_W_DEF = 18;
  localparam int BYTE_W_DEF = 9;
endpackage

// File: rtl/sram2_array.sv
`timescale 1ns/1ps
module sram2_array #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        wa_i,
  input  logic [WORD_W-1:0]        wd0_i,
  input  logic [WORD_W-1:0]        wd1_i,
  input  logic [WORD_W/BYTE_W-1:0] be0_i,
  input  logic [WORD_W/BYTE_W-1:0] be1_i,
  input  logic [ADDR_W-1:0]        ra_i,
  output logic [WORD_W-1:0]        rd0_o,
  output logic [WORD_W-1:0]        rd1_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NB    = WORD_W / BYTE_W;

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0] wa_odd;
  logic [WORD_W-1:0] cur0;

  assign wa_odd = wa_i ^ ADDR_W'(1);
  assign cur0   = mem_q[wa_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < NB; b++) begin
        if (be0_i[b]) mem_q[wa_i][b*BYTE_W +: BYTE_W]   <= wd0_i[b*BYTE_W +: BYTE_W];
        if (be1_i[b]) mem_q[wa_odd][b*BYTE_W +: BYTE_W] <= wd1_i[b*BYTE_W +: BYTE_W];
      end
    end
  end

  assign rd0_o = mem_q[ra_i];
  assign rd1_o = mem_q[ra_i ^ ADDR_W'(1)];

  for (genvar b = 0; b < NB; b++) begin : g_keep
    // R4: masked byte of the lane-0 word is left untouched by a commit
    a_r4_masked_byte_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && !be0_i[b]) |=>
        (mem_q[$past(wa_i)][b*BYTE_W +: BYTE_W] == $past(cur0[b*BYTE_W +: BYTE_W])));
  end
endmodule

// File: rtl/sram2_post.sv
`timescale 1ns/1ps
module sram2_post #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 18,
  parameter int BYTE_W = 9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cap_i,
  input  logic [ADDR_W-1:0]        ca_i,
  input  logic [WORD_W-1:0]        d0_i,
  input  logic [WORD_W-1:0]        d1_i,
  input  logic [WORD_W/BYTE_W-1:0] be0_i,
  input  logic [WORD_W/BYTE_W-1:0] be1_i,
  output logic                     cm_we_o,
  output logic [ADDR_W-1:0]        cm_a_o,
  output logic [WORD_W-1:0]        cm_d0_o,
  output logic [WORD_W-1:0]        cm_d1_o,
  output logic [WORD_W/BYTE_W-1:0] cm_be0_o,
  output logic [WORD_W/BYTE_W-1:0] cm_be1_o,
  input  logic [ADDR_W-1:0]        ra_i,
  input  logic [WORD_W-1:0]        arr0_i,
  input  logic [WORD_W-1:0]        arr1_i,
  output logic [WORD_W-1:0]        rd0_o,
  output logic [WORD_W-1:0]        rd1_o
);
  localparam int NB = WORD_W / BYTE_W;

  logic                       pv_q;
  logic [ADDR_W-1:0]          pa_q;
  logic [1:0][WORD_W-1:0]     pd_q;
  logic [1:0][NB-1:0]         pb_q;
  logic [1:0][WORD_W-1:0]     arr, mrg;

  // new write data arrives: old entry goes to the array, new one is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= 1'b0;
      pa_q <= '0;
      pd_q <= '0;
      pb_q <= '0;
    end else if (cap_i) begin
      pv_q <= 1'b1;
      pa_q <= ca_i;
      pd_q <= {d1_i, d0_i};
      pb_q <= {be1_i, be0_i};
    end
  end

  assign cm_we_o  = cap_i & pv_q;
  assign cm_a_o   = pa_q;
  assign cm_d0_o  = pd_q[0];
  assign cm_d1_o  = pd_q[1];
  assign cm_be0_o = pb_q[0];
  assign cm_be1_o = pb_q[1];

  assign arr = {arr1_i, arr0_i};

  always_comb begin
    mrg = arr;
    for (int j = 0; j < 2; j++) begin
      for (int k = 0; k < 2; k++) begin
        if (pv_q && ((ra_i ^ ADDR_W'(j)) == (pa_q ^ ADDR_W'(k)))) begin
          for (int b = 0; b < NB; b++) begin
            if (pb_q[k][b]) mrg[j][b*BYTE_W +: BYTE_W] = pd_q[k][b*BYTE_W +: BYTE_W];
          end
        end
      end
    end
  end

  assign rd0_o = mrg[0];
  assign rd1_o = mrg[1];

  // R5: held entry persists until the next write's data arrives
  a_r5_held_until_next_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pv_q && !cap_i) |=> ($stable(pd_q) && $stable(pa_q) && $stable(pb_q) && pv_q));
endmodule

// File: rtl/sram2_rdpipe.sv
`timescale 1ns/1ps
module sram2_rdpipe #(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              norm_i,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] d0_i,
  input  logic [WORD_W-1:0] d1_i,
  output logic              rvalid_o,
  output logic [WORD_W-1:0] rd0_o,
  output logic [WORD_W-1:0] rd1_o
);
  logic              v1_q, v2_q;
  logic [WORD_W-1:0] a1_q, b1_q, a2_q, b2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0; a1_q <= '0; b1_q <= '0;
      v2_q <= 1'b0; a2_q <= '0; b2_q <= '0;
    end else begin
      v1_q <= vld_i;
      a1_q <= vld_i ? d0_i : '0;
      b1_q <= vld_i ? d1_i : '0;
      v2_q <= v1_q;
      a2_q <= a1_q;
      b2_q <= b1_q;
    end
  end

  // extra stage stands in for the half-cycle of the long latency
  assign rvalid_o = norm_i ? v2_q : v1_q;
  assign rd0_o    = norm_i ? a2_q : a1_q;
  assign rd1_o    = norm_i ? b2_q : b1_q;

  // R8: lanes are quiet whenever no read data is presented
  a_r8_quiet_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_o |-> (rd0_o == '0 && rd1_o == '0));
endmodule

// File: rtl/burst2_sram.sv
`timescale 1ns/1ps
module burst2_sram
  import sram2_pkg::*;
#(
  parameter int ADDR_W = ADDR_W_DEF,
  parameter int WORD_W = WORD_W_DEF,
  parameter int BYTE_W = BYTE_W_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lat_norm_i,
  input  logic                     ld_ni,
  input  logic                     rw_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [WORD_W-1:0]        wdata0_i,
  input  logic [WORD_W-1:0]        wdata1_i,
  input  logic [WORD_W/BYTE_W-1:0] wbe0_i,
  input  logic [WORD_W/BYTE_W-1:0] wbe1_i,
  output logic [WORD_W-1:0]        rdata0_o,
  output logic [WORD_W-1:0]        rdata1_o,
  output logic                     rvalid_o
);
  localparam int NB = WORD_W / BYTE_W;

  logic              rcmd_q, wcmd_q;
  logic [ADDR_W-1:0] ra_q, wa_q;

  logic              cm_we;
  logic [ADDR_W-1:0] cm_a;
  logic [WORD_W-1:0] cm_d0, cm_d1, arr0, arr1, mrg0, mrg1;
  logic [NB-1:0]     cm_be0, cm_be1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcmd_q <= 1'b0;
      wcmd_q <= 1'b0;
      ra_q   <= '0;
      wa_q   <= '0;
    end else begin
      rcmd_q <= !ld_ni && rw_i;
      wcmd_q <= !ld_ni && !rw_i;
      if (!ld_ni && rw_i)  ra_q <= addr_i;
      if (!ld_ni && !rw_i) wa_q <= addr_i;
    end
  end

  sram2_post #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_post (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (wcmd_q),
    .ca_i     (wa_q),
    .d0_i     (wdata0_i),
    .d1_i     (wdata1_i),
    .be0_i    (wbe0_i),
    .be1_i    (wbe1_i),
    .cm_we_o  (cm_we),
    .cm_a_o   (cm_a),
    .cm_d0_o  (cm_d0),
    .cm_d1_o  (cm_d1),
    .cm_be0_o (cm_be0),
    .cm_be1_o (cm_be1),
    .ra_i     (ra_q),
    .arr0_i   (arr0),
    .arr1_i   (arr1),
    .rd0_o    (mrg0),
    .rd1_o    (mrg1)
  );

  sram2_array #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cm_we),
    .wa_i   (cm_a),
    .wd0_i  (cm_d0),
    .wd1_i  (cm_d1),
    .be0_i  (cm_be0),
    .be1_i  (cm_be1),
    .ra_i   (ra_q),
    .rd0_o  (arr0),
    .rd1_o  (arr1)
  );

  sram2_rdpipe #(.WORD_W(WORD_W)) u_rdpipe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .norm_i   (lat_norm_i),
    .vld_i    (rcmd_q),
    .d0_i     (mrg0),
    .d1_i     (mrg1),
    .rvalid_o (rvalid_o),
    .rd0_o    (rdata0_o),
    .rd1_o    (rdata1_o)
  );

  // R1: load high starts nothing
  a_r1_idle_no_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> (!rcmd_q && !wcmd_q));
  // R7: short latency, one edge after the command register
  a_r7_short_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lat_norm_i && rcmd_q) |=> rvalid_o);
  // R7: long latency, two edges after the command register
  a_r7_long_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lat_norm_i && rcmd_q) |=> ##1 rvalid_o);
endmodule

// File: tb/burst2_sram_tb.sv
`timescale 1ns/1ps
module burst2_sram_tb;
  localparam int N = 16;
  localparam int S = N + 4;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, lat_norm, ld_n, rw;
  logic [7:0]  addr;
  logic [17:0] wd0, wd1, rd0, rd1;
  logic [1:0]  be0, be1;
  logic        rvalid;

  burst2_sram u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lat_norm_i(lat_norm), .ld_ni(ld_n), .rw_i(rw),
    .addr_i(addr), .wdata0_i(wd0), .wdata1_i(wd1), .wbe0_i(be0), .wbe1_i(be1),
    .rdata0_o(rd0), .rdata1_o(rd1), .rvalid_o(rvalid)
  );

  int errs = 0, chks = 0;

  function automatic logic [49:0] mk(logic [1:0] op, logic [7:0] a, logic [17:0] d0,
                                     logic [17:0] d1, logic [1:0] b0, logic [1:0] b1);
    return {op, a, d0, d1, b0, b1};
  endfunction

  // op, addr, lane0, lane1, be0, be1
  localparam logic [49:0] VEC [N] = '{
    mk(OP_RD,   8'h10, 18'h0,     18'h0,     2'b00, 2'b00), // R10 cleared content
    mk(OP_WR,   8'h10, 18'h12345, 18'h0abcd, 2'b11, 2'b11), // R3
    mk(OP_RD,   8'h10, 18'h0,     18'h0,     2'b00, 2'b00), // R6 bypass next cycle
    mk(OP_RD,   8'h11, 18'h0,     18'h0,     2'b00, 2'b00), // R2 lane order, odd LSB
    mk(OP_IDLE, 8'h10, 18'h0,     18'h0,     2'b00, 2'b00), // R1 load high, rw low
    mk(OP_WR,   8'h20, 18'h1ffff, 18'h2a955, 2'b01, 2'b10), // R4 partial
    mk(OP_RD,   8'h20, 18'h0,     18'h0,     2'b00, 2'b00), // R6
    mk(OP_WR,   8'h20, 18'h2aaaa, 18'h15555, 2'b10, 2'b01), // R9 back to back, R5 commit
    mk(OP_RD,   8'h21, 18'h0,     18'h0,     2'b00, 2'b00), // R6 merge held over array
    mk(OP_WR,   8'h31, 18'h3ffff, 18'h3ffff, 2'b00, 2'b00), // R4 fully masked
    mk(OP_RD,   8'h30, 18'h0,     18'h0,     2'b00, 2'b00), // R4
    mk(OP_WR,   8'h40, 18'h11111, 18'h22222, 2'b11, 2'b11), // R5
    mk(OP_RD,   8'h10, 18'h0,     18'h0,     2'b00, 2'b00), // R1 idle left 0x10 alone
    mk(OP_RD,   8'h41, 18'h0,     18'h0,     2'b00, 2'b00), // R5 held across reads
    mk(OP_RD,   8'h40, 18'h0,     18'h0,     2'b00, 2'b00), // R9 read after read
    mk(OP_IDLE, 8'h40, 18'h0,     18'h0,     2'b00, 2'b00)
  };

  logic [17:0] mdl [256];
  logic        ev [S];
  logic [17:0] e0 [S];
  logic [17:0] e1 [S];

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle_in();
    ld_n = 1'b1; rw = 1'b1; addr = '0;
    wd0 = 18'h3ffff; wd1 = 18'h3ffff; be0 = 2'b11; be1 = 2'b11;
  endtask

  task automatic mdl_write(logic [7:0] a, logic [17:0] d0, logic [17:0] d1,
                           logic [1:0] b0, logic [1:0] b1);
    if (b0[0]) mdl[a][8:0]          = d0[8:0];
    if (b0[1]) mdl[a][17:9]         = d0[17:9];
    if (b1[0]) mdl[a ^ 8'h01][8:0]  = d1[8:0];
    if (b1[1]) mdl[a ^ 8'h01][17:9] = d1[17:9];
  endtask

  task automatic run_pass(logic norm);
    int lat;
    lat = norm ? 3 : 2;
    lat_norm = norm;
    idle_in();
    rst_n = 1'b0;
    for (int i = 0; i < 256; i++) mdl[i] = '0;
    for (int i = 0; i < S; i++) begin ev[i] = 1'b0; e0[i] = '0; e1[i] = '0; end
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 reset valid", {17'd0, rvalid}, 18'd0);
    chk("R10 reset lane0", rd0, 18'd0);
    for (int s = 0; s < S; s++) begin
      @(negedge clk);
      if (s >= lat && ev[s-lat]) begin
        chk("R7/R8 valid", {17'd0, rvalid}, 18'd1);
        chk("R2/R6 lane0", rd0, e0[s-lat]);
        chk("R2/R6 lane1", rd1, e1[s-lat]);
      end else begin
        chk("R8 valid low", {17'd0, rvalid}, 18'd0);
        chk("R8 lanes quiet", rd0 | rd1, 18'd0);
      end
      idle_in();
      if (s < N) begin
        addr = VEC[s][47:40];
        if (VEC[s][49:48] == OP_RD) begin
          ld_n = 1'b0; rw = 1'b1;
          ev[s] = 1'b1;
          e0[s] = mdl[VEC[s][47:40]];
          e1[s] = mdl[VEC[s][47:40] ^ 8'h01];
        end else if (VEC[s][49:48] == OP_WR) begin
          ld_n = 1'b0; rw = 1'b0;
          mdl_write(VEC[s][47:40], VEC[s][39:22], VEC[s][21:4], VEC[s][3:2], VEC[s][1:0]);
        end else begin
          rw = 1'b0; // R1: write-like inputs while load is high
        end
      end
      // R3: data lanes belong to the write of the previous slot
      if (s >= 1 && s - 1 < N && VEC[s-1][49:48] == OP_WR) begin
        wd0 = VEC[s-1][39:22]; wd1 = VEC[s-1][21:4];
        be0 = VEC[s-1][3:2];   be1 = VEC[s-1][1:0];
      end
    end
  endtask

  initial begin
    #(200000 * 5);
    errs++; chks++;
    $display("FAIL R9 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    lat_norm = 1'b1;
    idle_in();
    run_pass(1'b1);
    run_pass(1'b0);
    // R10: reset in the middle of a read clears the outputs
    @(negedge clk);
    ld_n = 1'b0; rw = 1'b1; addr = 8'h40;
    @(negedge clk);
    idle_in();
    rst_n = 1'b0;
    #1;
    chk("R10 mid-read valid", {17'd0, rvalid}, 18'd0);
    chk("R10 mid-read lane1", rd1, 18'd0);
    @(negedge clk);
    rst_n = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule